// File: doc/BRIEF.md
# Fixed-Width Truncated Radix-4 Booth Multiplier

This block multiplies two signed n-bit operands and returns only the upper n bits of the 2n-bit product. Most of the partial-product bits that fall in the low half of the product are never built. Their missing carry is replaced by an estimate that depends only on how many of the recoded multiplier digits are nonzero. This saves about half of the adder cells of a full-width multiplier. The cost is a small bounded error in the last output bits, which suits lossy datapaths such as filters and image arithmetic.

The multiplier operand is recoded into radix-4 digits. Each digit selects zero, one or two times the multiplicand, possibly negated. The rows that remain are summed with a combinational carry-save tree and one final adder. The result goes into a single output register, which is loaded when the valid strobe is high. A done flag marks the cycle in which a new result is visible.

Top module: `fw_booth_mul`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, prod_o is 0 and done_o is 0.
- R2: done_o is 1 in exactly the cycle that follows a clock edge at which valid_i was 1, and is 0 otherwise.
- R3: A clock edge with valid_i low leaves prod_o unchanged.
- R4: The multiplier b is recoded into n/2 digits. Digit j is d_j = -2*b[2j+1] + b[2j] + b[2j-1], taking values in {-2,-1,0,+1,+2}, with b[-1] = 0. Row j carries weight 4^j.
- R5: A digit whose bit b[2j+1] is 1 gives a negative row. That row is the bitwise inverse of the (n+1)-bit pattern |d_j|*a, with a correction 1 at column 2j. The pattern 111 counts as negative zero: an all-ones row plus its correction.
- R6: Let D be the weighted sum of the row bits and corrections that lie in columns below n-1. Let pc be the pre-add carry of R7, I the compensation of R8, and S = a*b - D + 2^(n-1)*(pc + 1 + I). Then prod_o is floor(S / 2^n) mod 2^n.
- R7: The lowest bit of the last row and that row's correction both sit in column n-2. Their AND (pc) is kept as a carry into column n-1.
- R8: The compensation is I = floor((σ-1)/2), where σ is the number of nonzero digits, and I = 0 when σ = 0. For n = 8, I is 1 when at least 3 of the 4 digits are nonzero.
- R9: One rounding 1 is added at column n-1 for every operand pair.
- R10: For every operand pair, |prod_o*2^n - a*b| ≤ 3*2^n, with prod_o read as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operands are sampled at this clock edge |
| a_i | input | N | Signed multiplicand |
| b_i | input | N | Signed multiplier (recoded) |
| prod_o | output | N | Upper N bits of the approximate product |
| done_o | output | 1 | A new result is on prod_o |

## Verification
Any fault in the recoding, the row polarity, the pre-add carry or the compensation changes the sum of the kept columns. It therefore shows up on prod_o in the cycle right after the valid edge, but only for operand pairs whose low columns produce a carry near the truncation line. This is why every signed operand pair is applied once and compared against an arithmetic model of the kept columns. A wrong register enable or a wrong flag shows up within one cycle as a changed value during idle cycles or as a misplaced done pulse.

// File: rtl/fwbm_pkg.sv
package fwbm_pkg;

    // One recoded radix-4 digit: sign and magnitude select
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdig_t;

    // Number of compensation bits produced from the sorted nonzero flags
    function automatic int comp_width(int digits);
        return (digits >= 3) ? (digits - 1) / 2 : 1;
    endfunction

endpackage

// File: rtl/fwbm_recoder.sv
module fwbm_recoder
    import fwbm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]         b_i,
    output bdig_t [N/2-1:0]      dig_o,
    output logic  [N/2-1:0]      nz_o
);
    localparam int D = N / 2;

    logic [N:0] b_ext;
    assign b_ext = {b_i, 1'b0};

    for (genvar j = 0; j < D; j++) begin : g_dig
        logic hi, mid, lo;
        assign hi  = b_ext[2*j+2];
        assign mid = b_ext[2*j+1];
        assign lo  = b_ext[2*j];
        assign dig_o[j].neg = hi;
        assign dig_o[j].one = mid ^ lo;
        assign dig_o[j].two = (hi & ~mid & ~lo) | (~hi & mid & lo);
        assign nz_o[j]      = (mid ^ lo) | (hi ^ mid);
    end

endmodule

// File: rtl/fwbm_sorter.sv
module fwbm_sorter #(
    parameter int D = 4
) (
    input  logic [D-1:0] nz_i,
    output logic [D-1:0] sorted_o
);
    // Odd-even transposition network of AND/OR pairs: ones gather at index 0
    logic [D-1:0] st [D+1];
    assign st[0] = nz_i;

    for (genvar s = 0; s < D; s++) begin : g_stage
        for (genvar i = 0; i < D; i++) begin : g_lane
            if ((i % 2 == s % 2) && (i + 1 < D)) begin : g_hi
                assign st[s+1][i] = st[s][i] | st[s][i+1];
            end else if ((i >= 1) && ((i - 1) % 2 == s % 2)) begin : g_lo
                assign st[s+1][i] = st[s][i-1] & st[s][i];
            end else begin : g_pass
                assign st[s+1][i] = st[s][i];
            end
        end
    end

    assign sorted_o = st[D];

endmodule

// File: rtl/fwbm_pp_window.sv
module fwbm_pp_window
    import fwbm_pkg::*;
#(
    parameter int N = 8,
    parameter int M = 1
) (
    input  logic [N-1:0]                  a_i,
    input  bdig_t [N/2-1:0]               dig_i,
    input  logic [M-1:0]                  comp_i,
    output logic [N/2+2+M-1:0][N:0]       rows_o
);
    localparam int D = N / 2;
    localparam int W = N + 1;

    // Sign-extension constant folded into the kept window, plus rounding 1
    function automatic logic [W-1:0] fold_const();
        logic [2*N-1:0] acc;
        logic [2*N-1:0] unit;
        acc  = '0;
        unit = 1;
        for (int j = 0; j < D; j++) begin
            acc = acc - (unit << (2*j + N));
        end
        return acc[2*N-1:N-1] | W'(1);
    endfunction

    localparam logic [W-1:0] FOLD_K = fold_const();

    // Bit k of the (n+1)-bit row selected by a digit, inverted when negative
    function automatic logic row_bit(bdig_t d, logic [N-1:0] a, int k);
        logic [N:0] ext, dbl, mag;
        ext = {a[N-1], a};
        dbl = {a, 1'b0};
        mag = d.one ? ext : (d.two ? dbl : '0);
        return mag[k] ^ d.neg;
    endfunction

    always_comb begin
        int k;
        rows_o = '0;
        for (int j = 0; j < D; j++) begin
            for (int w = 0; w < W; w++) begin
                k = w + N - 1 - 2*j;
                if (k >= 0 && k < N) begin
                    rows_o[j][w] = row_bit(dig_i[j], a_i, k);
                end else if (k == N) begin
                    rows_o[j][w] = ~row_bit(dig_i[j], a_i, N);
                end
            end
        end
        rows_o[D] = FOLD_K;
        // pre-added lowest bit and correction of the last row: carry survives
        rows_o[D+1][0] = row_bit(dig_i[D-1], a_i, 0) & dig_i[D-1].neg;
        for (int i = 0; i < M; i++) begin
            rows_o[D+2+i][0] = comp_i[i];
        end
    end

endmodule

// File: rtl/fwbm_csa_reduce.sv
module fwbm_csa_reduce #(
    parameter int W    = 9,
    parameter int ROWS = 7
) (
    input  logic [ROWS-1:0][W-1:0] rows_i,
    output logic [W-1:0]           sum_o
);
    localparam int SLOTS = ROWS + 2;

    always_comb begin
        logic [W-1:0] cur [SLOTS];
        logic [W-1:0] nxt [SLOTS];
        int cnt;
        int ncnt;
        for (int i = 0; i < SLOTS; i++) begin
            cur[i] = (i < ROWS) ? rows_i[i] : '0;
            nxt[i] = '0;
        end
        cnt = ROWS;
        for (int s = 0; s < ROWS; s++) begin
            if (cnt > 2) begin
                for (int i = 0; i < SLOTS; i++) nxt[i] = '0;
                ncnt = 0;
                for (int g = 0; g < ROWS; g += 3) begin
                    if (g + 2 < cnt) begin
                        nxt[ncnt]   = cur[g] ^ cur[g+1] ^ cur[g+2];
                        nxt[ncnt+1] = ((cur[g] & cur[g+1]) | (cur[g] & cur[g+2])
                                       | (cur[g+1] & cur[g+2])) << 1;
                        ncnt = ncnt + 2;
                    end else if (g < cnt) begin
                        nxt[ncnt] = cur[g];
                        ncnt = ncnt + 1;
                        if (g + 1 < cnt) begin
                            nxt[ncnt] = cur[g+1];
                            ncnt = ncnt + 1;
                        end
                    end
                end
                for (int i = 0; i < SLOTS; i++) cur[i] = nxt[i];
                cnt = ncnt;
            end
        end
        sum_o = cur[0] + ((cnt > 1) ? cur[1] : '0);
    end

endmodule

// File: rtl/fw_booth_mul.sv
module fw_booth_mul
    import fwbm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         valid_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] prod_o,
    output logic         done_o
);
    localparam int D    = N / 2;
    localparam int W    = N + 1;
    localparam int M    = comp_width(D);
    localparam int ROWS = D + 2 + M;

    typedef struct packed {
        logic [N-1:0] prod;
        logic         done;
    } state_t;

    bdig_t [D-1:0]           dig;
    logic  [D-1:0]           nz;
    logic  [D-1:0]           sorted;
    logic  [M-1:0]           comp;
    logic  [ROWS-1:0][W-1:0] rows;
    logic  [W-1:0]           win_sum;
    state_t                  st_d, st_q;

    fwbm_recoder #(.N(N)) u_rec (
        .b_i   (b_i),
        .dig_o (dig),
        .nz_o  (nz)
    );

    fwbm_sorter #(.D(D)) u_sort (
        .nz_i     (nz),
        .sorted_o (sorted)
    );

    // every second sorted position above the first gives one compensation unit
    for (genvar k = 1; k <= M; k++) begin : g_comp
        if (2*k < D) begin : g_tap
            assign comp[k-1] = sorted[2*k];
        end else begin : g_zero
            assign comp[k-1] = 1'b0;
        end
    end

    fwbm_pp_window #(.N(N), .M(M)) u_pp (
        .a_i    (a_i),
        .dig_i  (dig),
        .comp_i (comp),
        .rows_o (rows)
    );

    fwbm_csa_reduce #(.W(W), .ROWS(ROWS)) u_tree (
        .rows_i (rows),
        .sum_o  (win_sum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = valid_i;
        if (valid_i) begin
            st_d.prod = win_sum[W-1:1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = st_q.prod;
    assign done_o = st_q.done;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (prod_o == '0 && !done_o));

    // R2
    done_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> done_o);

    // R2
    no_stray_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !done_o);

    // R3
    prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(prod_o));

    // R8
    comp_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(comp) == (($countones(nz) == 0) ? 0 : ($countones(nz) - 1) / 2));

    for (genvar i = 0; i + 1 < D; i++) begin : g_order
        // R8
        sorted_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sorted[i+1] |-> sorted[i]);
    end

    for (genvar j = 0; j < D; j++) begin : g_digchk
        // R4
        digit_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({dig[j].one, dig[j].two}) && (nz[j] == (dig[j].one | dig[j].two)));
    end

endmodule

// File: tb/fw_booth_mul_bench.sv
module fw_booth_mul_bench;
    localparam int N = 8;
    localparam int D = N / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [N-1:0] prod;
    logic         done;

    int    n_checks = 0;
    int    n_errors = 0;
    int    exp_prod = 0;
    int    exp_done = 0;
    int    last_a = 0;
    int    last_b = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;

    fw_booth_mul #(.N(N)) u_fw_booth_mul (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .valid_i (valid),
        .a_i     (a),
        .b_i     (b),
        .prod_o  (prod),
        .done_o  (done)
    );

    // Arithmetic model of the kept columns (R4..R9)
    function automatic int model(int av, int bv);
        int dropped = 0;
        int sigma = 0;
        int pc = 0;
        int rmask = (1 << (N + 1)) - 1;
        int s, comp;
        for (int j = 0; j < D; j++) begin
            int bm1 = (j == 0) ? 0 : ((bv >> (2*j - 1)) & 1);
            int b0  = (bv >> (2*j)) & 1;
            int b1  = (bv >> (2*j + 1)) & 1;
            int d   = -2*b1 + b0 + bm1;
            int mag = (d < 0) ? -d : d;
            int row = (b1 == 1) ? ((~(mag * av)) & rmask) : ((mag * av) & rmask);
            if (d != 0) sigma++;
            if (2*j < N - 1) begin
                dropped += (row & ((1 << (N - 1 - 2*j)) - 1)) << (2*j);
                dropped += b1 << (2*j);
            end
            if (j == D - 1) pc = row & b1 & 1;
        end
        comp = (sigma == 0) ? 0 : (sigma - 1) / 2;
        s = av * bv - dropped + ((pc + 1 + comp) << (N - 1));
        return (s >>> N) & ((1 << N) - 1);
    endfunction

    // cycle model
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_prod = 0;
            exp_done = 0;
        end else begin
            exp_done = valid ? 1 : 0;
            if (valid) begin
                last_a   = $signed(a);
                last_b   = $signed(b);
                exp_prod = model(last_a, last_b);
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            string ptag;
            ptag = !rst_n ? "R1" : (exp_done == 1 ? tag : "R3");
            n_checks++;
            if (int'(done) != exp_done) begin
                n_errors++;
                $display("FAIL %s R2 done: actual=%0d expected=%0d", ptag, done, exp_done);
            end
            n_checks++;
            if (int'(prod) != exp_prod) begin
                n_errors++;
                $display("FAIL %s a=%0d b=%0d prod: actual=%0d expected=%0d",
                         ptag, last_a, last_b, prod, exp_prod);
            end
            if (rst_n && exp_done == 1) begin
                int err = int'($signed(prod)) * (1 << N) - last_a * last_b;
                n_checks++;
                if (err > 3 * (1 << N) || err < -3 * (1 << N)) begin
                    n_errors++;
                    $display("FAIL R10 a=%0d b=%0d error bound: actual=%0d expected within %0d",
                             last_a, last_b, err, 3 * (1 << N));
                end
            end
        end
    end

    task automatic drive(input int av, input int bv, input string t);
        @(negedge clk);
        #1;
        a     = N'(av);
        b     = N'(bv);
        valid = 1'b1;
        tag   = t;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1;
            valid = 1'b0;
            a     = N'(i * 37 + 5);
            b     = N'(i * 91 + 3);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        // R1: reset held for a few cycles, then one idle cycle after release
        repeat (4) @(negedge clk);
        #1;
        rst_n = 1'b1;
        idle(2);
        // R4: extreme operands and the lowest digit fed by b[-1] = 0
        drive(-128, -128, "R4");
        drive(127, 1, "R4");
        drive(-128, 127, "R4");
        // R5: all-ones multiplier gives negative-zero digits and a -1 digit
        drive(113, -1, "R5");
        drive(-77, -2, "R5");
        // R7: last digit negative, odd multiplicand
        drive(1, -128, "R7");
        drive(-3, -105, "R7");
        // R8: no nonzero digit, then all digits nonzero
        drive(99, 0, "R8");
        drive(-99, 85, "R8");
        drive(45, 2, "R8");
        // R9: small products that only the rounding bit can lift
        drive(1, 1, "R9");
        drive(-1, 1, "R9");
        // R3: inputs move while valid is low
        idle(5);
        // R6 and R10: every signed operand pair
        for (int ai = -(1 << (N - 1)); ai < (1 << (N - 1)); ai++) begin
            for (int bi = -(1 << (N - 1)); bi < (1 << (N - 1)); bi++) begin
                drive(ai, bi, "R6");
            end
        end
        idle(3);
        @(negedge clk);
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule